// File: doc/BRIEF.md
# JTAG Identification-Code Probe Master

This block is a small JTAG master that tests whether one candidate assignment of pins reaches a working test access port. After a start pulse it drives the clock, the mode-select line and the data input toward the target. It first forces the target's TAP into its reset state. It then steps the TAP into the data-register shift state and clocks out one or more 32-bit words, sampling the target's data output on every rising clock edge. Finally it steps the TAP through Exit1-DR to Update-DR.

After reset, a TAP's data register holds its 32-bit identification code. A correct assignment therefore returns a word with a recognisable mix of ones and zeros. A wrong assignment returns a line stuck at one level. The block does not compare against a known code. It marks each captured word as valid when the word contains both bit values. An all-zero or all-one word is marked as a stuck link.

The data input cannot be located by this method, so it is held at a fixed level for the whole scan. A chain of several TAPs shifts out several codes back to back, so the number of 32-bit words is chosen at each start, up to a parameter limit. Every word gets its own verdict. An outer controller handles the choice of pins and any retries.

Top module: `jtag_id_probe`

## Requirements
- R1: While reset is held and after it: `tck` is 0, `tms` is 1, `busy` and `done` are 0, and all of `id_words` and `word_valid` are 0.
- R2: A start pulse while idle begins a probe. The first five TCK cycles carry TMS 1. The next four carry TMS 0, 1, 0, 0. From any prior TAP state this leaves the TAP in Shift-DR.
- R3: The probe then issues 32×N TCK cycles with TMS 0 and samples `tdo` at each TCK rise. The k-th sampled bit (k from 0) is placed at `id_words[k]`, so word w occupies bits 32w+31..32w with its first bit at the LSB. N is `n_words`, with 0 treated as 1 and values above MAX_WORDS treated as MAX_WORDS.
- R4: Two final TCK cycles carry TMS 1, 1, leaving the TAP in Update-DR. A probe issues exactly 11+32×N rising TCK edges. TMS is 1 whenever the block is idle.
- R5: `word_valid[w]` is 1 exactly when captured word w holds at least one 0 and at least one 1. Words at index N and above read as 0 with `word_valid` 0.
- R6: TMS changes only in the clock cycle in which TCK falls. `tdi` stays at TDI_LEVEL (default 1) at all times.
- R7: Each TCK high phase and each low phase lasts `div`+1 clock cycles. `div` is sampled at start, so later changes do not affect the probe in progress. TCK rises only while busy.
- R8: `done` is high for exactly one cycle at the end of a probe, in the same cycle that `busy` falls. `id_words` and `word_valid` change only in that cycle and hold their values until the next probe ends.
- R9: A start pulse while busy is ignored. The probe in progress keeps its word count, timing and results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a probe |
| div | input | DIV_W | TCK half period minus one, in clock cycles |
| n_words | input | NW_W | Number of 32-bit words to shift out |
| tdo | input | 1 | Data output of the target |
| tck | output | 1 | Test clock toward the target |
| tms | output | 1 | Mode select toward the target |
| tdi | output | 1 | Data input toward the target, held constant |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle end-of-probe pulse |
| word_valid | output | MAX_WORDS | Per-word verdict: 1 means mixed bits, 0 means stuck |
| id_words | output | 32*MAX_WORDS | Captured words, first sampled bit in bit 0 |

## Verification
The bench drives a behavioural TAP with the full sixteen-state controller. This model starts in the IR-shift state, so a probe that skipped or shortened the reset walk would leave the TAP elsewhere and capture garbage. It also tests a two-word probe against a single-TAP chain: the second word fills with the constant data input and must be judged stuck, and an off-by-one bit index would corrupt both words. Word-count values 0 and 3 check the clamping rule. A mid-probe change of divider and a second start pulse check that the timing and length latched at start hold, because a design that re-read its inputs would stretch TCK or run 32 extra cycles. A probe against a stuck line checks that earlier results stay on the outputs until the final cycle.

// File: rtl/jprobe_pkg.sv
package jprobe_pkg;
  localparam int WORD_W      = 32;
  localparam int RESET_CYC   = 5;
  localparam int WALK_CYC    = 4;
  localparam int EXIT_CYC    = 2;
  localparam int SHIFT_START = RESET_CYC + WALK_CYC;
  localparam int FIXED_CYC   = SHIFT_START + EXIT_CYC;

  typedef enum logic [0:0] {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_t;
endpackage

// File: rtl/jprobe_tckgen.sv
module jprobe_tckgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half_m1,
  output logic             tck,
  output logic             rise_ev,
  output logic             fall_ev
);
  logic [DIV_W-1:0] cnt_q;
  logic             tck_q;
  logic             wrap;

  assign wrap    = run && (cnt_q == half_m1);
  assign rise_ev = wrap && !tck_q;
  assign fall_ev = wrap && tck_q;
  assign tck     = tck_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      tck_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      tck_q <= ~tck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/jprobe_capture.sv
module jprobe_capture
  import jprobe_pkg::*;
#(
  parameter int WORDS = 2,
  parameter int IDX_W = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic                    wr_bit,
  input  logic                    commit,
  output logic [WORD_W*WORDS-1:0] words_q,
  output logic [WORDS-1:0]        valid_q
);
  logic [WORD_W*WORDS-1:0] work_q;
  logic [WORDS-1:0]        mixed;

  generate
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      // a word is usable only if it carries both levels
      assign mixed[w] = (|work_q[w*WORD_W +: WORD_W]) && !(&work_q[w*WORD_W +: WORD_W]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      work_q  <= '0;
      words_q <= '0;
      valid_q <= '0;
    end else begin
      if (clear)
        work_q <= '0;
      else if (wr_en)
        work_q[wr_idx] <= wr_bit;
      if (commit) begin
        words_q <= work_q;
        valid_q <= mixed;
      end
    end
  end
endmodule

// File: rtl/jtag_id_probe.sv
module jtag_id_probe
  import jprobe_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int MAX_WORDS = 2,
  parameter bit TDI_LEVEL = 1'b1,
  parameter int NW_W      = $clog2(MAX_WORDS + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic [DIV_W-1:0]            div,
  input  logic [NW_W-1:0]             n_words,
  input  logic                        tdo,
  output logic                        tck,
  output logic                        tms,
  output logic                        tdi,
  output logic                        busy,
  output logic                        done,
  output logic [MAX_WORDS-1:0]        word_valid,
  output logic [WORD_W*MAX_WORDS-1:0] id_words
);
  localparam int TOTAL_BITS = WORD_W * MAX_WORDS;
  localparam int MAX_CYC    = FIXED_CYC + TOTAL_BITS;
  localparam int CYC_W      = $clog2(MAX_CYC + 1);
  localparam int IDX_W      = (TOTAL_BITS > 1) ? $clog2(TOTAL_BITS) : 1;

  phase_t           phase_q;
  logic [CYC_W-1:0] cyc_q;
  logic [CYC_W-1:0] last_q;
  logic [CYC_W-1:0] last_d;
  logic [CYC_W-1:0] rel;
  logic [DIV_W-1:0] div_q;
  logic [NW_W-1:0]  nw_eff;
  logic             tms_q;
  logic             done_q;
  logic             running;
  logic             rise_ev;
  logic             fall_ev;
  logic             in_shift;
  logic             at_end;

  // clamp the requested word count into 1..MAX_WORDS
  always_comb begin
    if (n_words == '0)
      nw_eff = NW_W'(1);
    else if (int'(n_words) > MAX_WORDS)
      nw_eff = NW_W'(MAX_WORDS);
    else
      nw_eff = n_words;
  end

  assign last_d = CYC_W'(FIXED_CYC - 1) + CYC_W'(WORD_W) * CYC_W'(nw_eff);

  // TMS level for TCK cycle c of a probe whose final cycle is last
  function automatic logic tms_for(input logic [CYC_W-1:0] c, input logic [CYC_W-1:0] last);
    if (c < CYC_W'(RESET_CYC))        return 1'b1;
    if (c == CYC_W'(RESET_CYC + 1))   return 1'b1;
    if (c + CYC_W'(1) >= last)        return 1'b1;
    return 1'b0;
  endfunction

  assign running  = (phase_q == PH_RUN);
  assign rel      = cyc_q - CYC_W'(SHIFT_START);
  assign in_shift = running && (cyc_q >= CYC_W'(SHIFT_START)) && (cyc_q + CYC_W'(1) < last_q);
  assign at_end   = fall_ev && (cyc_q == last_q);

  jprobe_tckgen #(
    .DIV_W (DIV_W)
  ) u_tck (
    .clk     (clk),
    .rst     (rst),
    .run     (running),
    .half_m1 (div_q),
    .tck     (tck),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev)
  );

  jprobe_capture #(
    .WORDS (MAX_WORDS),
    .IDX_W (IDX_W)
  ) u_cap (
    .clk     (clk),
    .rst     (rst),
    .clear   (start && !running),
    .wr_en   (rise_ev && in_shift),
    .wr_idx  (rel[IDX_W-1:0]),
    .wr_bit  (tdo),
    .commit  (at_end),
    .words_q (id_words),
    .valid_q (word_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cyc_q   <= '0;
      last_q  <= '0;
      div_q   <= '0;
      tms_q   <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          if (start) begin
            phase_q <= PH_RUN;
            cyc_q   <= '0;
            last_q  <= last_d;
            div_q   <= div;
            tms_q   <= 1'b1;
          end
        end
        default: begin
          if (fall_ev) begin
            if (cyc_q == last_q) begin
              phase_q <= PH_IDLE;
              done_q  <= 1'b1;
              tms_q   <= 1'b1;
            end else begin
              cyc_q <= cyc_q + 1'b1;
              tms_q <= tms_for(cyc_q + 1'b1, last_q);
            end
          end
        end
      endcase
    end
  end

  assign tms  = tms_q;
  assign tdi  = TDI_LEVEL;
  assign busy = running;
  assign done = done_q;
endmodule

// File: rtl/jtag_id_probe_chk.sv
module jtag_id_probe_chk #(
  parameter int MAX_WORDS = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    tck,
  input logic                    tms,
  input logic                    busy,
  input logic                    done,
  input logic [MAX_WORDS-1:0]    word_valid,
  input logic [32*MAX_WORDS-1:0] id_words
);
  AST_TMS_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(tms) |-> $fell(tck)); // R6

  AST_TCK_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(tck) |-> busy); // R7

  AST_IDLE_TMS_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> tms); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R8

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$stable(id_words) || !$stable(word_valid)) |-> done); // R8
endmodule

bind jtag_id_probe jtag_id_probe_chk #(
  .MAX_WORDS (MAX_WORDS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tck        (tck),
  .tms        (tms),
  .busy       (busy),
  .done       (done),
  .word_valid (word_valid),
  .id_words   (id_words)
);

// File: tb/jtag_id_probe_tb.sv
module jtag_id_probe_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DIV_W     = 8;
  localparam int MAX_WORDS = 2;
  localparam int NW_W      = 2;
  localparam bit TDI       = 1'b1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [DIV_W-1:0] div = '0;
  logic [NW_W-1:0]  n_words = 2'd1;
  logic             tdo;
  logic             tck, tms, tdi, busy, done;
  logic [1:0]       word_valid;
  logic [63:0]      id_words;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  jtag_id_probe #(
    .DIV_W     (DIV_W),
    .MAX_WORDS (MAX_WORDS),
    .TDI_LEVEL (TDI),
    .NW_W      (NW_W)
  ) u_dut (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .div        (div),
    .n_words    (n_words),
    .tdo        (tdo),
    .tck        (tck),
    .tms        (tms),
    .tdi        (tdi),
    .busy       (busy),
    .done       (done),
    .word_valid (word_valid),
    .id_words   (id_words)
  );

  // behavioural target TAP
  typedef enum logic [3:0] {TLR, RTI, SDRS, CDR, SDR, E1DR, PDR, E2DR, UDR,
                            SIRS, CIR, SIR, E1IR, PIR, E2IR, UIR} tap_t;

  function automatic tap_t tap_next(tap_t s, logic m);
    case (s)
      TLR:  return m ? TLR  : RTI;
      RTI:  return m ? SDRS : RTI;
      SDRS: return m ? SIRS : CDR;
      CDR:  return m ? E1DR : SDR;
      SDR:  return m ? E1DR : SDR;
      E1DR: return m ? UDR  : PDR;
      PDR:  return m ? E2DR : PDR;
      E2DR: return m ? UDR  : SDR;
      UDR:  return m ? SDRS : RTI;
      SIRS: return m ? TLR  : CIR;
      CIR:  return m ? E1IR : SIR;
      SIR:  return m ? E1IR : SIR;
      E1IR: return m ? UIR  : PIR;
      PIR:  return m ? E2IR : PIR;
      E2IR: return m ? UIR  : SIR;
      default: return m ? SDRS : RTI;
    endcase
  endfunction

  tap_t        tap = SIR;
  logic [63:0] dr = '0;
  logic        tdo_tap = 1'b0;
  int          ntap = 1;
  int          mode = 0;
  logic [31:0] id0 = '0;
  logic [31:0] id1 = '0;

  function automatic logic [63:0] shift_in(logic [63:0] d, int n, logic b);
    logic [63:0] r;
    r = d >> 1;
    r[n*32-1] = b;
    return r;
  endfunction

  always @(posedge tck) begin
    if (tap == CDR)
      dr <= (ntap == 2) ? {id1, id0} : {32'h0, id0};
    else if (tap == SDR)
      dr <= shift_in(dr, ntap, tdi);
    tap <= tap_next(tap, tms);
  end

  always @(negedge tck) tdo_tap <= dr[0];

  assign tdo = (mode == 0) ? tdo_tap : (mode == 1) ? 1'b0 : 1'b1;

  int rise_cnt = 0;
  int tdi_bad  = 0;
  always @(posedge tck) rise_cnt++;
  always @(posedge clk) if (tdi !== TDI) tdi_bad++;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    #(150000 * 5);
    fails++;
    $display("FAIL R8 watchdog: actual=no completion expected=done");
    summary();
    $finish;
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0]  mode;
    logic [1:0]  ntap;
    logic [1:0]  nw;
    logic [3:0]  dv;
    logic [31:0] id1;
    logic [31:0] id0;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{2'd0, 2'd1, 2'd1, 4'd1, 32'h0,        32'h4BA00477},
    '{2'd1, 2'd1, 2'd1, 4'd0, 32'h0,        32'h0},
    '{2'd2, 2'd1, 2'd2, 4'd2, 32'h0,        32'h0},
    '{2'd0, 2'd2, 2'd2, 4'd0, 32'h16410041, 32'h0BA01477},
    '{2'd0, 2'd1, 2'd2, 4'd1, 32'h0,        32'h12345679},
    '{2'd0, 2'd2, 2'd1, 4'd3, 32'hCAFE0001, 32'h2BA01477},
    '{2'd0, 2'd1, 2'd0, 4'd0, 32'h0,        32'h00000001},
    '{2'd0, 2'd2, 2'd3, 4'd1, 32'h80000000, 32'hFFFFFFFE},
    '{2'd0, 2'd1, 2'd1, 4'd0, 32'h0,        32'hFFFFFFFF}
  };

  function automatic int eff_words(logic [1:0] nw);
    if (nw == 0) return 1;
    if (nw > 2) return 2;
    return int'(nw);
  endfunction

  function automatic logic [63:0] exp_stream(vec_t v);
    logic [63:0] r;
    case (v.mode)
      2'd1:    r = '0;
      2'd2:    r = '1;
      default: r = (v.ntap == 2) ? {v.id1, v.id0} : {{32{TDI}}, v.id0};
    endcase
    if (eff_words(v.nw) == 1) r[63:32] = '0;
    return r;
  endfunction

  function automatic logic [1:0] exp_valid(logic [63:0] s);
    logic [1:0] r;
    for (int w = 0; w < 2; w++)
      r[w] = (s[w*32 +: 32] != 32'h0) && (s[w*32 +: 32] != 32'hFFFFFFFF);
    return r;
  endfunction

  task automatic pulse_start(logic [3:0] dv, logic [1:0] nw);
    @(negedge clk);
    div = DIV_W'(dv);
    n_words = nw;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic apply(vec_t v);
    int base_r, base_t;
    logic [63:0] es;
    mode = int'(v.mode);
    ntap = int'(v.ntap);
    id0  = v.id0;
    id1  = v.id1;
    es   = exp_stream(v);
    base_r = rise_cnt;
    base_t = tdi_bad;
    pulse_start(v.dv, v.nw);
    wait_done();
    check("R3 captured words", id_words, es);
    check("R5 word verdicts", 64'(word_valid), 64'(exp_valid(es)));
    check("R4 rising TCK count", 64'(rise_cnt - base_r), 64'(11 + 32 * eff_words(v.nw)));
    check("R2 R4 TAP end state Update-DR", 64'(tap), 64'(UDR));
    check("R6 tdi constant", 64'(tdi_bad - base_t), 64'd0);
    check("R8 busy low with done", 64'(busy), 64'd0);
    @(negedge clk);
    check("R8 done one cycle", 64'(done), 64'd0);
  endtask

  initial begin
    int n;
    int base_r;
    logic [63:0] prev;

    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 tck reset", 64'(tck), 64'd0);
    check("R1 tms reset", 64'(tms), 64'd1);
    check("R1 busy/done reset", 64'({busy, done}), 64'd0);
    check("R1 results reset", id_words | 64'(word_valid), 64'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 idle after reset", 64'({tck, tms, busy, done}), 64'b0100);

    // vector table (first run starts with the TAP in Shift-IR: R2)
    foreach (VECS[i]) apply(VECS[i]);

    // R7 and R9: divider latched, restart ignored while busy
    mode = 0; ntap = 1; id0 = 32'hA5A5A5A5;
    base_r = rise_cnt;
    pulse_start(4'd4, 2'd1);
    @(posedge tck);
    n = 0;
    do begin @(posedge clk); #1; n++; end while (tck);
    check("R7 half period div+1", 64'(n), 64'd5);
    @(negedge clk);
    div = 8'd9;
    n_words = 2'd2;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(posedge tck);
    n = 0;
    do begin @(posedge clk); #1; n++; end while (tck);
    check("R7 div change mid-probe ignored", 64'(n), 64'd5);
    wait_done();
    check("R9 restart ignored: length", 64'(rise_cnt - base_r), 64'd43);
    check("R9 restart ignored: words", id_words, {32'h0, 32'hA5A5A5A5});
    check("R9 restart ignored: verdict", 64'(word_valid), 64'b01);

    // R8 results held during a probe and after done
    prev = id_words;
    mode = 1;
    pulse_start(4'd0, 2'd1);
    repeat (20) @(negedge clk);
    check("R8 results held mid-probe", id_words, prev);
    check("R8 verdict held mid-probe", 64'(word_valid), 64'b01);
    wait_done();
    check("R5 stuck-low verdict", 64'(word_valid), 64'd0);
    check("R3 stuck-low word", id_words, 64'd0);
    mode = 2;
    repeat (10) @(negedge clk);
    check("R8 results held after done", id_words, 64'd0);
    check("R8 no repeat done", 64'({busy, done}), 64'd0);

    summary();
    $finish;
  end
endmodule